// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This block decides where the processor goes when an instruction raises an exception. It also produces the special-register updates that go with that decision. On a request it picks one of three vectors: double, user or kernel. The choice depends on the exception-mode and user-mode bits of the processor status word. The block then saves the faulting program counter in the right register, records the cause code, and optionally records a faulting virtual address. It returns the status word with the exception-mode bit forced on, and it redirects the program counter to the faulting address.

The dispatch is single-cycle and has no memory of earlier requests. A request strobe sampled at a rising clock edge produces all outputs from registers right after that edge. Every write enable, the one-hot vector select and the "exception taken" flag each last exactly one cycle. The data outputs hold their last written value. A separate configuration input says whether a dedicated register exists for the PC of a nested exception.

Top module: `exc_dispatch`

## Requirements
- R1: While reset is active, and in the first cycle after it, every write enable, `excTaken` and `vecSel` are zero.
- R2: A request made while status bit EXCM_BIT (default 4) is set selects the double vector, `vecSel` = 3'b100, whatever the user-mode bit is.
- R3: A request made with EXCM_BIT clear and status bit UM_BIT (default 5) set selects the user vector, `vecSel` = 3'b010.
- R4: A request made with EXCM_BIT clear and UM_BIT clear selects the kernel vector, `vecSel` = 3'b001.
- R5: On a double exception with `hasDepc` high, the faulting PC is written to the double-exception PC output (`depcWe`, `depcData`) and `epc1We` stays low.
- R6: On a double exception with `hasDepc` low, the faulting PC is written to the level-1 PC output (`epc1We`, `epc1Data`) and `depcWe` stays low.
- R7: On a non-nested exception, the faulting PC is written to the level-1 PC output and `depcWe` stays low, whatever `hasDepc` is.
- R8: Every request writes `causeCode` to the cause output (`causeWe`, `causeData`).
- R9: Every request writes the status word (`statusWe`) with bit EXCM_BIT set and every other bit equal to `statusIn`.
- R10: A request with `vaddrValid` high writes `vaddr` to the virtual-address output (`vaddrWe`, `vaddrData`). With `vaddrValid` low, `vaddrWe` stays low.
- R11: Every request writes the faulting PC to the program-counter output (`pcWe`, `pcOut`).
- R12: `excTaken` and all write enables are high for exactly the one cycle after the edge at which `excReq` was sampled high. A cycle without a request leaves them low and the data outputs unchanged.
- R13: Requests in consecutive cycles are each dispatched on their own edge from their own inputs, with no queueing and no merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception request strobe |
| faultPc | input | PC_W | PC of the faulting instruction |
| causeCode | input | CAUSE_W | Exception cause code |
| vaddr | input | PC_W | Faulting virtual address |
| vaddrValid | input | 1 | The request carries a virtual address |
| statusIn | input | STAT_W | Current processor status word |
| hasDepc | input | 1 | Configuration has a double-exception PC register |
| vecSel | output | 3 | One-hot vector: bit0 kernel, bit1 user, bit2 double |
| excTaken | output | 1 | One-cycle pulse per dispatched exception |
| depcWe | output | 1 | Double-exception PC write enable |
| depcData | output | PC_W | Double-exception PC data |
| epc1We | output | 1 | Level-1 exception PC write enable |
| epc1Data | output | PC_W | Level-1 exception PC data |
| causeWe | output | 1 | Cause register write enable |
| causeData | output | CAUSE_W | Cause register data |
| vaddrWe | output | 1 | Virtual-address register write enable |
| vaddrData | output | PC_W | Virtual-address register data |
| statusWe | output | 1 | Status word write enable |
| statusOut | output | STAT_W | Updated status word |
| pcWe | output | 1 | Program counter redirect enable |
| pcOut | output | PC_W | New program counter |

## Verification
Every result of this block is due exactly one clock edge after the edge that sampled the request. This holds for the vector select, the taken pulse, each write enable and each data value. Idle cycles are due in the same way and must show all enables low. The driver changes inputs on the falling edge and pushes one expected item per cycle, idle cycles included. The monitor pops one item 2 ns after each rising edge, so each comparison lines up with the single register stage. Data outputs are compared only in cycles where their enable is expected high, and they are also checked to hold when no request is made.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W = 3;
  localparam logic [VEC_W-1:0] VEC_NONE   = 3'b000;
  localparam logic [VEC_W-1:0] VEC_KERNEL = 3'b001;
  localparam logic [VEC_W-1:0] VEC_USER   = 3'b010;
  localparam logic [VEC_W-1:0] VEC_DOUBLE = 3'b100;

  // Strobes the control hands to the datapath for one request cycle.
  typedef struct packed {
    logic take;
    logic saveDepc;
    logic saveEpc1;
    logic latchVaddr;
  } strobe_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int STAT_W   = 32,
  parameter int EXCM_BIT = 4,
  parameter int UM_BIT   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic              vaddrValid,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              hasDepc,
  output strobe_t           strobes,
  output logic [VEC_W-1:0]  vecSel,
  output logic              excTaken
);
  logic nested;
  logic userMode;
  logic [VEC_W-1:0] vecNext;

  assign nested   = statusIn[EXCM_BIT];
  assign userMode = statusIn[UM_BIT];

  always_comb begin
    if (nested)        vecNext = VEC_DOUBLE;
    else if (userMode) vecNext = VEC_USER;
    else               vecNext = VEC_KERNEL;
  end

  always_comb begin
    strobes.take       = excReq;
    strobes.saveDepc   = excReq & nested & hasDepc;
    strobes.saveEpc1   = excReq & ~(nested & hasDepc);
    strobes.latchVaddr = excReq & vaddrValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecSel   <= VEC_NONE;
      excTaken <= 1'b0;
    end else begin
      vecSel   <= excReq ? vecNext : VEC_NONE;
      excTaken <= excReq;
    end
  end

  assert_double_vec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && statusIn[EXCM_BIT]) |=> (vecSel == VEC_DOUBLE));
  assert_onehot_vec_R3: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> ($countones(vecSel) == 1));
  assert_taken_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> (!excTaken && vecSel == VEC_NONE));
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CAUSE_W  = 6,
  parameter int STAT_W   = 32,
  parameter int EXCM_BIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [PC_W-1:0]    faultPc,
  input  logic [CAUSE_W-1:0] causeCode,
  input  logic [PC_W-1:0]    vaddr,
  input  logic [STAT_W-1:0]  statusIn,
  output logic               depcWe,
  output logic [PC_W-1:0]    depcData,
  output logic               epc1We,
  output logic [PC_W-1:0]    epc1Data,
  output logic               causeWe,
  output logic [CAUSE_W-1:0] causeData,
  output logic               vaddrWe,
  output logic [PC_W-1:0]    vaddrData,
  output logic               statusWe,
  output logic [STAT_W-1:0]  statusOut,
  output logic               pcWe,
  output logic [PC_W-1:0]    pcOut
);
  localparam logic [STAT_W-1:0] EXCM_MASK = STAT_W'(1) << EXCM_BIT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depcWe   <= 1'b0;
      epc1We   <= 1'b0;
      causeWe  <= 1'b0;
      vaddrWe  <= 1'b0;
      statusWe <= 1'b0;
      pcWe     <= 1'b0;
    end else begin
      depcWe   <= strobes.saveDepc;
      epc1We   <= strobes.saveEpc1;
      causeWe  <= strobes.take;
      vaddrWe  <= strobes.latchVaddr;
      statusWe <= strobes.take;
      pcWe     <= strobes.take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depcData  <= '0;
      epc1Data  <= '0;
      causeData <= '0;
      vaddrData <= '0;
      statusOut <= '0;
      pcOut     <= '0;
    end else begin
      if (strobes.saveDepc)   depcData  <= faultPc;
      if (strobes.saveEpc1)   epc1Data  <= faultPc;
      if (strobes.latchVaddr) vaddrData <= vaddr;
      if (strobes.take) begin
        causeData <= causeCode;
        statusOut <= statusIn | EXCM_MASK;
        pcOut     <= faultPc;
      end
    end
  end

  assert_pc_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(depcWe && epc1We));
  assert_status_excm_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> statusOut[EXCM_BIT]);
  assert_vaddr_with_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    vaddrWe |-> causeWe);
  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |=> $stable(pcOut));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CAUSE_W  = 6,
  parameter int STAT_W   = 32,
  parameter int EXCM_BIT = 4,
  parameter int UM_BIT   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic [PC_W-1:0]    faultPc,
  input  logic [CAUSE_W-1:0] causeCode,
  input  logic [PC_W-1:0]    vaddr,
  input  logic               vaddrValid,
  input  logic [STAT_W-1:0]  statusIn,
  input  logic               hasDepc,
  output logic [2:0]         vecSel,
  output logic               excTaken,
  output logic               depcWe,
  output logic [PC_W-1:0]    depcData,
  output logic               epc1We,
  output logic [PC_W-1:0]    epc1Data,
  output logic               causeWe,
  output logic [CAUSE_W-1:0] causeData,
  output logic               vaddrWe,
  output logic [PC_W-1:0]    vaddrData,
  output logic               statusWe,
  output logic [STAT_W-1:0]  statusOut,
  output logic               pcWe,
  output logic [PC_W-1:0]    pcOut
);
  strobe_t strobes;

  exc_ctrl #(.STAT_W(STAT_W), .EXCM_BIT(EXCM_BIT), .UM_BIT(UM_BIT)) ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .vaddrValid(vaddrValid),
    .statusIn(statusIn), .hasDepc(hasDepc), .strobes(strobes),
    .vecSel(vecSel), .excTaken(excTaken)
  );

  exc_datapath #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .STAT_W(STAT_W),
                 .EXCM_BIT(EXCM_BIT)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .faultPc(faultPc),
    .causeCode(causeCode), .vaddr(vaddr), .statusIn(statusIn),
    .depcWe(depcWe), .depcData(depcData), .epc1We(epc1We), .epc1Data(epc1Data),
    .causeWe(causeWe), .causeData(causeData), .vaddrWe(vaddrWe),
    .vaddrData(vaddrData), .statusWe(statusWe), .statusOut(statusOut),
    .pcWe(pcWe), .pcOut(pcOut)
  );
endmodule

// File: tb/exc_dispatch_test.sv
`timescale 1ns/1ps
module exc_dispatch_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excReq = 1'b0;
  logic [31:0] faultPc = '0;
  logic [5:0] causeCode = '0;
  logic [31:0] vaddr = '0;
  logic vaddrValid = 1'b0;
  logic [31:0] statusIn = '0;
  logic hasDepc = 1'b0;
  logic [2:0] vecSel;
  logic excTaken, depcWe, epc1We, causeWe, vaddrWe, statusWe, pcWe;
  logic [31:0] depcData, epc1Data, vaddrData, statusOut, pcOut;
  logic [5:0] causeData;

  always #5 clk = ~clk;

  exc_dispatch uut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .faultPc(faultPc),
    .causeCode(causeCode), .vaddr(vaddr), .vaddrValid(vaddrValid),
    .statusIn(statusIn), .hasDepc(hasDepc), .vecSel(vecSel),
    .excTaken(excTaken), .depcWe(depcWe), .depcData(depcData),
    .epc1We(epc1We), .epc1Data(epc1Data), .causeWe(causeWe),
    .causeData(causeData), .vaddrWe(vaddrWe), .vaddrData(vaddrData),
    .statusWe(statusWe), .statusOut(statusOut), .pcWe(pcWe), .pcOut(pcOut)
  );

  typedef struct {
    logic [2:0] vec;
    logic taken, depcWe, epc1We, causeWe, vaddrWe, statusWe, pcWe;
    logic [31:0] pc, va, status;
    logic [5:0] cause;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int takenCount = 0;
  logic [31:0] lastPc = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: status bit 4 = exception mode, bit 5 = user mode.
  task automatic drive(input bit req, input logic [31:0] pc, input logic [5:0] cause,
                       input logic [31:0] va, input bit vav, input logic [31:0] st,
                       input bit depc);
    exp_t e;
    bit nestedExc;
    @(negedge clk);
    excReq = req; faultPc = pc; causeCode = cause; vaddr = va;
    vaddrValid = vav; statusIn = st; hasDepc = depc;
    nestedExc = st[4];
    e.vec      = !req ? 3'b000 : nestedExc ? 3'b100 : st[5] ? 3'b010 : 3'b001;
    e.taken    = req;
    e.depcWe   = req && nestedExc && depc;
    e.epc1We   = req && !(nestedExc && depc);
    e.causeWe  = req;
    e.vaddrWe  = req && vav;
    e.statusWe = req;
    e.pcWe     = req;
    e.pc       = pc;
    e.va       = va;
    e.status   = st | 32'h10;
    e.cause    = cause;
    q.push_back(e);
  endtask

  // Monitor: results are due one edge after the request edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        string vtag;
        e = q.pop_front();
        vtag = (e.vec == 3'b100) ? "R2 vec" : (e.vec == 3'b010) ? "R3 vec" :
               (e.vec == 3'b001) ? "R4 vec" : "R12 vec idle";
        chk(vecSel == e.vec, vtag, 64'(vecSel), 64'(e.vec));
        chk(excTaken == e.taken, "R12 taken", 64'(excTaken), 64'(e.taken));
        chk(depcWe == e.depcWe, "R5 depcWe", 64'(depcWe), 64'(e.depcWe));
        chk(epc1We == e.epc1We, "R6/R7 epc1We", 64'(epc1We), 64'(e.epc1We));
        chk(vaddrWe == e.vaddrWe, "R10 vaddrWe", 64'(vaddrWe), 64'(e.vaddrWe));
        chk(causeWe == e.causeWe && statusWe == e.statusWe && pcWe == e.pcWe,
            "R12 enables", {61'd0, causeWe, statusWe, pcWe},
            {61'd0, e.causeWe, e.statusWe, e.pcWe});
        if (e.depcWe) chk(depcData == e.pc, "R5 depcData", 64'(depcData), 64'(e.pc));
        if (e.epc1We) chk(epc1Data == e.pc, "R7 epc1Data", 64'(epc1Data), 64'(e.pc));
        if (e.vaddrWe) chk(vaddrData == e.va, "R10 vaddrData", 64'(vaddrData), 64'(e.va));
        if (e.taken) begin
          takenCount++;
          chk(causeData == e.cause, "R8 cause", 64'(causeData), 64'(e.cause));
          chk(statusOut == e.status, "R9 status", 64'(statusOut), 64'(e.status));
          chk(pcOut == e.pc, "R11 pcOut", 64'(pcOut), 64'(e.pc));
          lastPc = e.pc;
        end else begin
          chk(pcOut == lastPc, "R12 pcOut hold", 64'(pcOut), 64'(lastPc));
        end
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk({excTaken, depcWe, epc1We, causeWe, vaddrWe, statusWe, pcWe} == 7'd0
        && vecSel == 3'b000, "R1 reset outputs", 64'(vecSel), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    chk(excTaken == 1'b0 && vecSel == 3'b000, "R1 after reset", 64'(excTaken), 64'd0);

    drive(1, 32'h0000_1000, 6'd3, 32'h0, 0, 32'h0000_0000, 0);  // R4 kernel
    drive(0, 32'h0, 6'd0, 32'h0, 0, 32'h0, 0);                  // R12 idle
    drive(1, 32'h0000_2004, 6'd9, 32'h0, 0, 32'h0000_0020, 1);  // R3 user, R7 with depc cfg
    drive(1, 32'h0000_3008, 6'd12, 32'h0, 0, 32'h0000_0010, 1); // R2/R5 double with depc
    drive(1, 32'h0000_400C, 6'd28, 32'h0, 0, 32'h0000_0030, 0); // R2/R6 double, no depc
    drive(1, 32'h8000_0010, 6'd5, 32'hDEAD_BEE0, 1, 32'hFFFF_FFCF, 0); // R10 + R9 passthrough
    drive(0, 32'hFFFF_FFFF, 6'd63, 32'h1234_5678, 1, 32'h10, 1);  // R12 ignored
    drive(0, 32'h0, 6'd0, 32'h0, 0, 32'h0, 0);
    // R13 back-to-back requests, each different
    drive(1, 32'h0000_5000, 6'd1, 32'hA5A5_0000, 1, 32'h0000_0000, 1);
    drive(1, 32'h0000_6000, 6'd2, 32'h0, 0, 32'h0000_0020, 1);
    drive(1, 32'h0000_7000, 6'd4, 32'h5A5A_0004, 1, 32'hA5A5_A5B5, 1);
    drive(0, 32'h0, 6'd0, 32'h0, 0, 32'h0, 0);
    drive(0, 32'h0, 6'd0, 32'h0, 0, 32'h0, 0);
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    chk(takenCount == 8, "R13 taken count", 64'(takenCount), 64'd8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule